// File: doc/BRIEF.md
# Inter-Processor Byte Mailbox

This block carries a stream of bytes from a master processor to a slave processor through one holding register. The master frames a burst with a level signal and sends each byte with an active-low write strobe. The falling transition of the strobe marks a byte as pending by raising a sync flag. The rising transition loads the data and pulses an interrupt to the slave for one cycle. The slave then reads the holding register with a read strobe, which also clears the sync flag. It answers with an acknowledge strobe, which sets a flag the master can see. The master clears that flag with a confirmation strobe and then sends the next byte.

After the last byte the master drops the frame signal. The slave treats the burst as complete once the frame signal and the sync flag are both low. A sticky overrun flag records a new write that starts while a byte is still unread. All strobes are synchronous to one clock, and reset is active low.

Top module: `byte_mailbox`

## Requirements
- R1: After reset, the holding register is 0, and `sync_flag`, `ack_flag`, `overrun` and `slv_irq` are all 0.
- R2: When `mst_wr_n` is sampled low in a cycle after it was sampled high, `sync_flag` is 1 from the next cycle.
- R3: When `mst_wr_n` is sampled high in a cycle after it was sampled low, the value of `mst_data` in that cycle is loaded into the holding register. `slv_irq` is 1 for exactly the following cycle.
- R4: `slv_data` equals the holding register while `slv_rd` is 1 and is 0 while `slv_rd` is 0. This is combinational.
- R5: `slv_rd` clears `sync_flag` from the next cycle. If a write falling transition arrives in the same cycle, the flag is set instead.
- R6: `slv_ack` sets `ack_flag` from the next cycle and `mst_confirm` clears it. When both are 1 in the same cycle, the flag is set.
- R7: `xfer_done` is 1 exactly when `mst_frame` is 0 and `sync_flag` is 0. `frame_status` follows `mst_frame`.
- R8: `overrun` becomes 1 when a write falling transition arrives while `sync_flag` is 1. It then stays 1 until reset.
- R9: The holding register keeps its value in every cycle without a write rising transition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| mst_wr_n | input | 1 | Master write strobe, active low |
| mst_data | input | 8 | Master byte to send |
| mst_frame | input | 1 | Burst framing level from master |
| mst_confirm | input | 1 | Master confirmation strobe, clears acknowledge |
| slv_irq | output | 1 | One-cycle interrupt to slave per byte |
| ack_flag | output | 1 | Acknowledge flag seen by master |
| slv_rd | input | 1 | Slave read strobe |
| slv_ack | input | 1 | Slave acknowledge strobe |
| slv_data | output | 8 | Holding register contents during a read, else 0 |
| sync_flag | output | 1 | Byte pending flag |
| frame_status | output | 1 | Frame signal as seen by slave |
| xfer_done | output | 1 | Burst complete indication |
| overrun | output | 1 | Sticky write-while-pending flag |

## Verification
The assertions assume the master holds `mst_wr_n` low for at least one sampled cycle before releasing it. They also assume `mst_data` is valid in the cycle of release. Under those conditions every transition produces exactly one fall event and one rise event. The bench drives each write as one low cycle followed by one release cycle, with data set up before the low phase. It uses the strobes only in the orders the requirements describe, except in the deliberate collision and overrun cases.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int unsigned BYTE_W = 8;

  function automatic logic fall_seen(input logic prev_q, input logic cur);
    return prev_q & ~cur;
  endfunction

  function automatic logic rise_seen(input logic prev_q, input logic cur);
    return ~prev_q & cur;
  endfunction

  function automatic logic flag_next(input logic q, input logic set,
                                     input logic clr, input logic set_wins);
    if (set_wins) return set | (q & ~clr);
    else          return ~clr & (set | q);
  endfunction
endpackage

// File: rtl/mbx_edge.sv
module mbx_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe_n,
  output logic fall_ev,
  output logic rise_ev
);
  import mbx_pkg::*;
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b1;
    else        prev_q <= strobe_n;
  end

  assign fall_ev = fall_seen(prev_q, strobe_n);
  assign rise_ev = rise_seen(prev_q, strobe_n);
endmodule

// File: rtl/mbx_flag.sv
module mbx_flag #(
  parameter bit SET_WINS = 1'b1,
  parameter bit STICKY   = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic q
);
  import mbx_pkg::*;
  logic clr_eff;

  generate
    if (STICKY) begin : g_sticky
      assign clr_eff = 1'b0;
    end else begin : g_clearable
      assign clr_eff = clr;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= 1'b0;
    else        q <= flag_next(q, set, clr_eff, SET_WINS);
  end
endmodule

// File: rtl/mbx_holding.sv
module mbx_holding #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [WIDTH-1:0] din,
  input  logic             rd,
  output logic [WIDTH-1:0] held,
  output logic [WIDTH-1:0] rd_bus
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    held <= '0;
    else if (load) held <= din;
  end

  assign rd_bus = rd ? held : '0;
endmodule

// File: rtl/byte_mailbox.sv
module byte_mailbox #(
  parameter int unsigned DATA_W = mbx_pkg::BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mst_wr_n,
  input  logic [DATA_W-1:0] mst_data,
  input  logic              mst_frame,
  input  logic              mst_confirm,
  output logic              slv_irq,
  output logic              ack_flag,
  input  logic              slv_rd,
  input  logic              slv_ack,
  output logic [DATA_W-1:0] slv_data,
  output logic              sync_flag,
  output logic              frame_status,
  output logic              xfer_done,
  output logic              overrun
);
  logic              wr_fall;
  logic              wr_rise;
  logic              overrun_hit;
  logic [DATA_W-1:0] latch_q;

  mbx_edge u_edge (
    .clk(clk), .rst_n(rst_n), .strobe_n(mst_wr_n),
    .fall_ev(wr_fall), .rise_ev(wr_rise)
  );

  mbx_holding #(.WIDTH(DATA_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .load(wr_rise), .din(mst_data),
    .rd(slv_rd), .held(latch_q), .rd_bus(slv_data)
  );

  mbx_flag #(.SET_WINS(1'b1), .STICKY(1'b0)) u_sync (
    .clk(clk), .rst_n(rst_n), .set(wr_fall), .clr(slv_rd), .q(sync_flag)
  );

  mbx_flag #(.SET_WINS(1'b1), .STICKY(1'b0)) u_ack (
    .clk(clk), .rst_n(rst_n), .set(slv_ack), .clr(mst_confirm), .q(ack_flag)
  );

  assign overrun_hit = wr_fall & sync_flag;

  mbx_flag #(.SET_WINS(1'b1), .STICKY(1'b1)) u_ovr (
    .clk(clk), .rst_n(rst_n), .set(overrun_hit), .clr(1'b0), .q(overrun)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) slv_irq <= 1'b0;
    else        slv_irq <= wr_rise;
  end

  assign frame_status = mst_frame;
  assign xfer_done    = ~mst_frame & ~sync_flag;
endmodule

// File: rtl/mbx_checker.sv
module mbx_checker #(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_fall,
  input logic              wr_rise,
  input logic [DATA_W-1:0] mst_data,
  input logic [DATA_W-1:0] latch_q,
  input logic              slv_irq,
  input logic              slv_rd,
  input logic              slv_ack,
  input logic              mst_confirm,
  input logic              sync_flag,
  input logic              ack_flag,
  input logic              overrun
);
  assert_sync_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fall |=> sync_flag);

  assert_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_rise |=> (latch_q == $past(mst_data)));

  assert_irq_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_rise |=> slv_irq);

  assert_irq_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    slv_irq |=> !slv_irq);

  assert_sync_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (slv_rd && !wr_fall) |=> !sync_flag);

  assert_ack_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    slv_ack |=> ack_flag);

  assert_ack_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mst_confirm && !slv_ack) |=> !ack_flag);

  assert_overrun_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun);

  assert_latch_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_rise |=> (latch_q == $past(latch_q)));
endmodule

bind byte_mailbox mbx_checker #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_fall(wr_fall), .wr_rise(wr_rise),
  .mst_data(mst_data), .latch_q(latch_q), .slv_irq(slv_irq),
  .slv_rd(slv_rd), .slv_ack(slv_ack), .mst_confirm(mst_confirm),
  .sync_flag(sync_flag), .ack_flag(ack_flag), .overrun(overrun)
);

// File: tb/byte_mailbox_test.sv
`timescale 1ns/1ps
module byte_mailbox_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mst_wr_n = 1'b1;
  logic [7:0] mst_data = 8'h00;
  logic       mst_frame = 1'b0;
  logic       mst_confirm = 1'b0;
  logic       slv_rd = 1'b0;
  logic       slv_ack = 1'b0;
  logic       slv_irq, ack_flag, sync_flag, frame_status, xfer_done, overrun;
  logic [7:0] slv_data;
  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  byte_mailbox uut (
    .clk(clk), .rst_n(rst_n), .mst_wr_n(mst_wr_n), .mst_data(mst_data),
    .mst_frame(mst_frame), .mst_confirm(mst_confirm), .slv_irq(slv_irq),
    .ack_flag(ack_flag), .slv_rd(slv_rd), .slv_ack(slv_ack),
    .slv_data(slv_data), .sync_flag(sync_flag), .frame_status(frame_status),
    .xfer_done(xfer_done), .overrun(overrun)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  // one low cycle then release; data valid throughout
  task automatic send(input logic [7:0] b);
    mst_data = b;
    mst_wr_n = 1'b0;
    step();
    chk("R2 sync set", {7'b0, sync_flag}, 8'd1);
    chk("R3 no irq yet", {7'b0, slv_irq}, 8'd0);
    mst_wr_n = 1'b1;
    step();
    chk("R3 irq pulse", {7'b0, slv_irq}, 8'd1);
  endtask

  function automatic logic [7:0] pat(input int i);
    return 8'((i * 37 + 11) & 255);
  endfunction

  initial begin
    #1;
    step();
    chk("R1 sync", {7'b0, sync_flag}, 8'd0);
    chk("R1 ack", {7'b0, ack_flag}, 8'd0);
    chk("R1 overrun", {7'b0, overrun}, 8'd0);
    chk("R1 irq", {7'b0, slv_irq}, 8'd0);
    slv_rd = 1'b1; #1;
    chk("R1 latch", slv_data, 8'h00);
    slv_rd = 1'b0;
    rst_n = 1'b1;
    step();

    mst_frame = 1'b1; #1;
    chk("R7 frame_status", {7'b0, frame_status}, 8'd1);
    chk("R7 done low in frame", {7'b0, xfer_done}, 8'd0);

    for (int i = 0; i < 256; i++) begin
      send(pat(i));
      mst_data = ~pat(i);
      step();
      chk("R3 irq one cycle", {7'b0, slv_irq}, 8'd0);
      chk("R4 idle bus", slv_data, 8'h00);
      chk("R9 pending", {7'b0, sync_flag}, 8'd1);
      slv_rd = 1'b1; #1;
      chk("R4 read data", slv_data, pat(i));
      step();
      slv_rd = 1'b0;
      chk("R5 sync cleared", {7'b0, sync_flag}, 8'd0);
      slv_rd = 1'b1; #1;
      chk("R9 hold", slv_data, pat(i));
      slv_rd = 1'b0;
      slv_ack = 1'b1;
      step();
      slv_ack = 1'b0;
      chk("R6 ack set", {7'b0, ack_flag}, 8'd1);
      mst_confirm = 1'b1;
      step();
      mst_confirm = 1'b0;
      chk("R6 ack cleared", {7'b0, ack_flag}, 8'd0);
      chk("R7 done low in frame", {7'b0, xfer_done}, 8'd0);
    end

    send(8'h5A);
    mst_frame = 1'b0; #1;
    chk("R7 pending blocks done", {7'b0, xfer_done}, 8'd0);
    chk("R7 frame_status low", {7'b0, frame_status}, 8'd0);
    slv_rd = 1'b1;
    step();
    slv_rd = 1'b0;
    chk("R7 done", {7'b0, xfer_done}, 8'd1);

    slv_ack = 1'b1; mst_confirm = 1'b1;
    step();
    slv_ack = 1'b0; mst_confirm = 1'b0;
    chk("R6 set wins", {7'b0, ack_flag}, 8'd1);
    mst_confirm = 1'b1; step(); mst_confirm = 1'b0;

    chk("R8 no overrun yet", {7'b0, overrun}, 8'd0);
    mst_data = 8'hC3; mst_wr_n = 1'b0; slv_rd = 1'b1;
    step();
    slv_rd = 1'b0;
    chk("R5 write wins over read", {7'b0, sync_flag}, 8'd1);
    mst_wr_n = 1'b1; step();
    send(8'h3C);
    chk("R8 overrun set", {7'b0, overrun}, 8'd1);
    slv_rd = 1'b1; #1;
    chk("R3 latest byte", slv_data, 8'h3C);
    step(); slv_rd = 1'b0;
    step(); step();
    chk("R8 overrun sticky", {7'b0, overrun}, 8'd1);

    rst_n = 1'b0; #1;
    chk("R1 overrun reset", {7'b0, overrun}, 8'd0);
    slv_rd = 1'b1; #1;
    chk("R1 latch reset", slv_data, 8'h00);
    slv_rd = 1'b0;
    finished = 1'b1;
  end

  initial begin
    for (int c = 0; c < 20000 && !finished; c++) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule